// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a clocked host and an asynchronous static RAM. The host presents one request at a time through a valid/ready handshake. A request carries a read or write flag, a byte address, write data, a per-lane byte mask and a width mode (full word, or single byte). The controller turns each request into a pin-level cycle. It drives the word address, a byte-select address line, a width-select line, an active-low and an active-high chip enable, active-low output and write enables, active-low lane enables and the direction of the data bus. For a read, it registers the returned data and reports it with a one-cycle valid pulse.

Every timing limit is a parameter in picoseconds, next to the clock period. Each limit becomes a whole number of clocks: the value is rounded up and is never less than one. The default values describe a 70 ns part on a 125 MHz clock.

A state machine with eight states runs each cycle:
- `ST_IDLE` accepts a request.
- A read goes through `ST_RD_SETUP`, `ST_RD_WAIT` and `ST_RD_CAPTURE`, then returns to `ST_IDLE`.
- A write goes through `ST_WR_SETUP`, `ST_WR_PULSE` and `ST_WR_HOLD`, then returns to `ST_IDLE`.
- When the previous access was a read, a write first passes through `ST_TURNAROUND` and then enters `ST_WR_SETUP`.
- `ST_RD_SETUP` always lasts one clock. Every other timed state leaves when its cycle counter reaches zero.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: Reset state. While reset is held and after it is released, the chip is deselected (active-low enable high, active-high enable low). Write enable and output enable are high, the bus is not driven, `rd_valid` is low and `req_ready` is high.
- R2: Handshake. `req_ready` is high only in idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low on the next cycle.
- R3: Address stability. The address, byte-select and width-select pins change only when write enable is high both before and after the change.
- R4: Write strobe and data window.
  - Write enable is low for exactly WP clocks, where WP is the largest of the rounded pulse width, data setup and lane-to-end-of-write times. With the defaults, WP is 5.
  - Both chip enables stay active while write enable is low.
  - The write data is driven from the first clock of write enable low until one clock after write enable rises, so the bus is driven for WP+1 clocks.
- R5: Write cycle length. A write with no turnaround keeps `req_ready` low for AS+WP+WH clocks. Here AS is the rounded address setup (at least 1) and WH is the larger of the rounded recovery time and WC-AS-WP. With the defaults this is 1+5+3 = 9 clocks, and `req_ready` is high again on clock 10 after acceptance.
- R6: Read timing.
  - Output enable goes low on the second clock after acceptance and stays low for RDW+1 clocks. RDW is the largest of AA-2, OE-1, RC-2 and 1; with the defaults it is 7.
  - The data is registered on the edge that ends `ST_RD_CAPTURE`. `rd_valid` is high for exactly one clock, clock RDW+3 after acceptance, which is also the first clock with `req_ready` high again.
- R7: Word-mode lanes (`req_wide`=1).
  - Lane enable n is the inverse of mask bit n, so mask `2'b01` gives lane pins `2'b10`.
  - Writes change only the enabled lanes.
  - On a read, a lane whose mask bit is 0 returns zero in `rd_data`.
- R8: Byte mode (`req_wide`=0).
  - The width-select pin is low, the byte-select pin equals address bit 0, and the word address pins equal address bits [ADDR_W:1].
  - Only the lower lane enable is active (pins `2'b10`).
  - Write data goes out on bits [7:0], and `rd_data` returns bus bits [7:0] with the upper byte zero.
- R9: The data bus is never driven while output enable is low.
- R10: Turnaround.
  - A write accepted while the last completed access was a read waits OHZ clocks in `ST_TURNAROUND` before `ST_WR_SETUP`. OHZ is the rounded output turn-off time, 4 with the defaults.
  - With the defaults, such a write lowers write enable on clock 6 after acceptance.
  - A write after a write has no gap.
- R11: Cycle counts. Every timing limit becomes ceil(limit / clock period) clocks, with a minimum of one. A 0 ns address setup therefore still costs one clock, and write enable falls on clock 2 after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | ADDR_W+1 | Byte address; bit 0 selects the byte in byte mode |
| req_wdata | input | DATA_W | Write data (byte mode uses bits [7:0]) |
| req_be | input | DATA_W/8 | Lane mask for word mode, active high |
| rd_valid | output | 1 | One-clock pulse marking `rd_data` |
| rd_data | output | DATA_W | Registered read data |
| mem_addr | output | ADDR_W | Word address pins |
| mem_bsel | output | 1 | Byte-select address line (byte mode only) |
| mem_wide | output | 1 | Width-select line, high for word organisation |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lane_n | output | DATA_W/8 | Active-low lane enables |
| mem_dq_out | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Bus drive enable toward the RAM |
| mem_dq_in | input | DATA_W | Data returned by the RAM |

## Verification
The inline assertions check the pin rules on every clock:
- the address pins move only while write enable is high;
- write enable is low only with both chip enables active and output enable high;
- the write pulse is at least its minimum length;
- the data window covers the write pulse and one clock after it;
- the bus is never driven against an active output enable, and never before the turn-off time has passed since output enable rose;
- the read valid pulse lasts one clock.

Other behaviour can only be shown by the directed scenarios against a bench memory model:
- the exact clock on which each strobe moves;
- whether partial-lane and byte-mode writes land in the right bytes;
- the zeroing of masked or upper lanes in read data;
- whether the turnaround gap appears only after a read.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_TURNAROUND
    } ctrl_state_e;

    // Round a picosecond limit up to whole clocks, never below one clock.
    function automatic int ps_to_clks(input int ps, input int clk_ps);
        int c;
        c = (ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              wide,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [LANES-1:0]  lane_n,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rd_fmt
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == 0) begin : g_low
            // Lane 0 carries the byte in byte mode.
            assign lane_n[l]                  = wide ? ~be[l] : 1'b0;
            assign dq_out[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
            assign rd_fmt[l*LANE_W +: LANE_W] = (!wide || be[l]) ?
                                                dq_in[l*LANE_W +: LANE_W] : '0;
        end else begin : g_high
            assign lane_n[l]                  = wide ? ~be[l] : 1'b1;
            assign dq_out[l*LANE_W +: LANE_W] = wide ? wdata[l*LANE_W +: LANE_W] : '0;
            assign rd_fmt[l*LANE_W +: LANE_W] = (wide && be[l]) ?
                                                dq_in[l*LANE_W +: LANE_W] : '0;
        end
    end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] data_in,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= capture;
            if (capture) begin
                data <= data_in;
            end
        end
    end

    AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R6

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int CLK_PS   = 8000,
    parameter int T_RC_PS  = 70000,
    parameter int T_AA_PS  = 70000,
    parameter int T_OE_PS  = 35000,
    parameter int T_WC_PS  = 70000,
    parameter int T_WP_PS  = 35000,
    parameter int T_AS_PS  = 0,
    parameter int T_WR_PS  = 0,
    parameter int T_DW_PS  = 30000,
    parameter int T_BW_PS  = 30000,
    parameter int T_OHZ_PS = 30000,
    localparam int LANES   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W:0]   req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_bsel,
    output logic              mem_wide,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_lane_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // Clock counts derived from the picosecond limits.
    localparam int AA_C  = ps_to_clks(T_AA_PS, CLK_PS);
    localparam int OE_C  = ps_to_clks(T_OE_PS, CLK_PS);
    localparam int RC_C  = ps_to_clks(T_RC_PS, CLK_PS);
    localparam int WC_C  = ps_to_clks(T_WC_PS, CLK_PS);
    localparam int AS_C  = ps_to_clks(T_AS_PS, CLK_PS);
    localparam int WR_C  = ps_to_clks(T_WR_PS, CLK_PS);
    localparam int OHZ_C = ps_to_clks(T_OHZ_PS, CLK_PS);
    localparam int WP_C  = max2(ps_to_clks(T_WP_PS, CLK_PS),
                                max2(ps_to_clks(T_DW_PS, CLK_PS), ps_to_clks(T_BW_PS, CLK_PS)));
    localparam int RDW_C = max2(max2(AA_C - 2, OE_C - 1), max2(RC_C - 2, 1));
    localparam int WH_C  = max2(WR_C, WC_C - AS_C - WP_C);
    localparam int MAX_C = max2(max2(RDW_C, WP_C), max2(max2(WH_C, OHZ_C), AS_C));
    localparam int CNT_W = $clog2(MAX_C + 1);

    ctrl_state_e state_q, state_d;

    logic [ADDR_W:0]   addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic              wide_q;
    logic              last_rd_q;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic [CNT_W-1:0]  tmr_cnt;
    logic              tmr_zero;
    logic              capture;
    logic              accept;
    logic [LANES-1:0]  lane_n_map;
    logic [DATA_W-1:0] rd_fmt;

    assign accept = req_valid && (state_q == ST_IDLE);

    sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .zero     (tmr_zero)
    );

    sram_lane_map #(.DATA_W(DATA_W), .LANE_W(8)) u_lanes (
        .wide   (wide_q),
        .be     (be_q),
        .wdata  (wdata_q),
        .dq_in  (mem_dq_in),
        .lane_n (lane_n_map),
        .dq_out (mem_dq_out),
        .rd_fmt (rd_fmt)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .data_in (rd_fmt),
        .valid   (rd_valid),
        .data    (rd_data)
    );

    // Next-state and timer-load decisions.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write) begin
                        state_d = ST_RD_SETUP;
                    end else if (last_rd_q) begin
                        state_d  = ST_TURNAROUND;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(OHZ_C - 1);
                    end else begin
                        state_d  = ST_WR_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(AS_C - 1);
                    end
                end
            end
            ST_RD_SETUP: begin
                state_d  = ST_RD_WAIT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RDW_C - 1);
            end
            ST_RD_WAIT: begin
                if (tmr_zero) state_d = ST_RD_CAPTURE;
            end
            ST_RD_CAPTURE: begin
                capture = 1'b1;
                state_d = ST_IDLE;
            end
            ST_TURNAROUND: begin
                if (tmr_zero) begin
                    state_d  = ST_WR_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(AS_C - 1);
                end
            end
            ST_WR_SETUP: begin
                if (tmr_zero) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WP_C - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    state_d  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WH_C - 1);
                end
            end
            ST_WR_HOLD: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
        endcase
    end

    // State register and request capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            wdata_q   <= '0;
            be_q      <= '0;
            wide_q    <= 1'b1;
            last_rd_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
                wide_q  <= req_wide;
            end
            if (state_q == ST_RD_CAPTURE) begin
                last_rd_q <= 1'b1;
            end else if (state_q == ST_WR_PULSE) begin
                last_rd_q <= 1'b0;
            end
        end
    end

    // Pin decode from the registered state.
    always_comb begin
        logic sel;
        sel        = 1'b0;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_TURNAROUND: sel = 1'b0;
            ST_RD_SETUP:            sel = 1'b1;
            ST_RD_WAIT, ST_RD_CAPTURE: begin
                sel      = 1'b1;
                mem_oe_n = 1'b0;
            end
            ST_WR_SETUP:            sel = 1'b1;
            ST_WR_PULSE: begin
                sel       = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                sel       = 1'b1;
                mem_dq_oe = (tmr_cnt == CNT_W'(WH_C - 1));
            end
        endcase
        mem_ce_n   = ~sel;
        mem_ce     = sel;
        mem_lane_n = sel ? lane_n_map : '1;
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_addr  = addr_q[ADDR_W:1];
    assign mem_bsel  = wide_q ? 1'b0 : addr_q[0];
    assign mem_wide  = wide_q;

    // Checker support: consecutive write-enable-low and output-enable-high clocks.
    logic [CNT_W-1:0] we_lo_cnt;
    logic [CNT_W-1:0] oe_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            oe_hi_cnt <= CNT_W'(OHZ_C);
        end else begin
            if (!mem_we_n)
                we_lo_cnt <= (we_lo_cnt == CNT_W'(WP_C)) ? we_lo_cnt : we_lo_cnt + 1'b1;
            else
                we_lo_cnt <= '0;
            if (mem_oe_n)
                oe_hi_cnt <= (oe_hi_cnt == CNT_W'(OHZ_C)) ? oe_hi_cnt : oe_hi_cnt + 1'b1;
            else
                oe_hi_cnt <= '0;
        end
    end

    AST_HANDSHAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_ADDR_MOVES_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({mem_addr, mem_bsel, mem_wide}) |-> (mem_we_n && $past(mem_we_n))); // R3

    AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n)); // R4

    AST_WE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && !$past(mem_we_n)) |-> (we_lo_cnt >= CNT_W'(WP_C))); // R4

    AST_DATA_COVERS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe); // R4

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && !$past(mem_we_n)) |-> mem_dq_oe); // R4

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R9

    AST_TURNOFF_ELAPSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (oe_hi_cnt >= CNT_W'(OHZ_C))); // R10

endmodule

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;

    // 125 MHz: 8 time units per period, one unit read as 1 ns.
    localparam int CLK_PS = 8000;

    function automatic int clks(input int ps);
        int c;
        c = (ps + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_AS  = clks(0);
    localparam int E_WP  = mx(clks(35000), mx(clks(30000), clks(30000)));
    localparam int E_WH  = mx(clks(0), clks(70000) - E_AS - E_WP);
    localparam int E_OHZ = clks(30000);
    localparam int E_RDW = mx(mx(clks(70000) - 2, clks(35000) - 1), mx(clks(70000) - 2, 1));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b1;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic        mem_bsel;
    logic        mem_wide;
    logic        mem_ce_n;
    logic        mem_ce;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    int checks = 0;
    int fails  = 0;
    int fights = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sram_cycle_ctrl u0 (.*);

    // Behavioural RAM: 16 words, upper lanes read 8'hEE when not enabled.
    logic [15:0] ram [16];
    logic        chip_on;
    assign chip_on = !mem_ce_n && mem_ce;

    always @(posedge clk) begin
        if (chip_on && !mem_we_n) begin
            if (mem_wide) begin
                if (!mem_lane_n[0]) ram[mem_addr[3:0]][7:0]  <= mem_dq_out[7:0];
                if (!mem_lane_n[1]) ram[mem_addr[3:0]][15:8] <= mem_dq_out[15:8];
            end else if (mem_bsel) begin
                ram[mem_addr[3:0]][15:8] <= mem_dq_out[7:0];
            end else begin
                ram[mem_addr[3:0]][7:0] <= mem_dq_out[7:0];
            end
        end
    end

    always_comb begin
        if (chip_on && !mem_oe_n && mem_we_n) begin
            if (mem_wide)
                mem_dq_in = {mem_lane_n[1] ? 8'hEE : ram[mem_addr[3:0]][15:8],
                             mem_lane_n[0] ? 8'hEE : ram[mem_addr[3:0]][7:0]};
            else
                mem_dq_in = {8'hEE, mem_bsel ? ram[mem_addr[3:0]][15:8] : ram[mem_addr[3:0]][7:0]};
        end else begin
            mem_dq_in = 16'hDEAD;
        end
    end

    always @(negedge clk) if (rst_n && mem_dq_oe && !mem_oe_n) fights++;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic wide, input logic [18:0] a,
                         input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wide;
        req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Write scenario: strobe timing, data window, pins seen at first WE-low clock.
    task automatic do_write(input logic wide, input logic [18:0] a, input logic [15:0] d,
                            input logic [1:0] be, input int gap, input logic [1:0] exp_lane);
        int we_first = 0, we_cnt = 0, oe_cnt = 0, oe_first = 0, rdy = 0;
        logic [15:0] dq_seen = '0;
        logic [17:0] ad = '0;
        logic bs = 1'b0, wd = 1'b0;
        logic [1:0] ln = '0;
        issue(1'b1, wide, a, d, be);
        check("R2", "ready low after accept", req_ready, 0);
        for (int c = 1; c <= 60; c++) begin
            if (!mem_we_n) begin
                if (we_first == 0) begin
                    we_first = c; dq_seen = mem_dq_out; ad = mem_addr;
                    bs = mem_bsel; wd = mem_wide; ln = mem_lane_n;
                end
                we_cnt++;
            end
            if (mem_dq_oe) begin
                if (oe_first == 0) oe_first = c;
                oe_cnt++;
            end
            if (req_ready) begin rdy = c; break; end
            @(negedge clk);
        end
        check("R10/R11", "WE fall clock", we_first, gap + E_AS + 1);
        check("R4", "WE low clocks", we_cnt, E_WP);
        check("R4", "bus drive clocks", oe_cnt, E_WP + 1);
        check("R4", "bus drive start", oe_first, we_first);
        check("R5", "ready return clock", rdy, gap + E_AS + E_WP + E_WH + 1);
        check("R3", "word address", ad, a[18:1]);
        check("R7/R8", "lane pins", ln, exp_lane);
        check("R8", "width pin", wd, wide);
        check("R8", "byte select", bs, wide ? 1'b0 : a[0]);
        if (wide) check("R4", "data on bus", dq_seen, d);
        else      check("R8", "byte on low lane", dq_seen[7:0], d[7:0]);
    endtask

    task automatic do_read(input logic wide, input logic [18:0] a, input logic [1:0] be,
                           input logic [15:0] exp);
        int oe_first = 0, oe_cnt = 0, rv_cyc = 0, rv_cnt = 0, rdy = 0;
        logic [15:0] got = '0;
        issue(1'b0, wide, a, 16'h0, be);
        for (int c = 1; c <= 60; c++) begin
            if (!mem_oe_n) begin
                if (oe_first == 0) oe_first = c;
                oe_cnt++;
            end
            if (rd_valid) begin rv_cyc = c; rv_cnt++; got = rd_data; end
            if (req_ready) begin rdy = c; break; end
            @(negedge clk);
        end
        @(negedge clk);
        if (rd_valid) rv_cnt++;
        check("R6", "OE fall clock", oe_first, 2);
        check("R6", "OE low clocks", oe_cnt, E_RDW + 1);
        check("R6", "valid clock", rv_cyc, E_RDW + 3);
        check("R6", "valid pulse length", rv_cnt, 1);
        check("R2", "ready return clock", rdy, E_RDW + 3);
        check(wide ? "R7" : "R8", "read data", got, exp);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) ram[i] = 16'h0;
        repeat (3) @(negedge clk);
        check("R1", "ce_n in reset", mem_ce_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready", req_ready, 1);
        check("R1", "chip enables", {mem_ce_n, mem_ce}, 2'b10);
        check("R1", "WE/OE", {mem_we_n, mem_oe_n}, 2'b11);
        check("R1", "bus drive / valid", {mem_dq_oe, rd_valid}, 2'b00);

        // Word write then read back.
        do_write(1'b1, 19'h14, 16'h1234, 2'b11, 0, 2'b00);
        do_read(1'b1, 19'h14, 2'b11, 16'h1234);
        // Write after read takes the turnaround gap; partial lanes.
        do_write(1'b1, 19'h14, 16'hABCD, 2'b01, E_OHZ, 2'b10);
        // Write after write: no gap.
        do_write(1'b1, 19'h14, 16'h9900, 2'b10, 0, 2'b01);
        do_read(1'b1, 19'h14, 2'b11, 16'h99CD);
        do_read(1'b1, 19'h14, 2'b01, 16'h00CD);
        // Byte mode into the upper byte of the same word.
        do_write(1'b0, 19'h15, 16'h775A, 2'b00, E_OHZ, 2'b10);
        do_read(1'b0, 19'h15, 2'b00, 16'h005A);
        do_read(1'b0, 19'h14, 2'b00, 16'h00CD);
        do_read(1'b1, 19'h14, 2'b11, 16'h5ACD);

        check("R9", "bus driven with OE low", fights, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule